// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital sequencer of a 10-bit successive-approximation converter. Once enabled, it holds the analog input in a sampling phase for a fixed number of clocks. It then resolves the code one bit per clock, from the MSB down, using an external comparator. The comparator reports whether the held input is at or above the trial code the block drives to the DAC. When the last bit is decided, the code is written left-justified into a 16-bit result word and a one-clock interrupt is raised. The next sampling phase begins at once, with no software action.

Software steers the block with a level-sensitive enable and a channel-rewrite strobe. A rewrite while enabled throws away the conversion in progress and starts sampling again. The one exception is a rewrite in the final decision cycle: that conversion is still delivered first. The result is a plain register, not a stream. There is no back-pressure, and each completion overwrites the previous value whether or not it was read. The analog comparator, the DAC and any bus wait-state logic are outside the block.

Top module: `sar_seq_top`

## Requirements
- R1: While reset is asserted and right after it, result is 16'h0000, and irq, sample_hold and trial_code are all zero.
- R2: When enable is high at a clock edge while the block is idle, sampling starts at that edge. sample_hold is then high for exactly SAMPLE_CLKS cycles (default 8), and trial_code is zero throughout.
- R3: Conversion follows sampling directly and takes RES_BITS (10) cycles. In step k (k = 0..9), trial_code is the bits already kept, OR-ed with the trial bit 9-k. That bit is kept only if cmp_ge is 1 in that cycle.
- R4: At the edge that closes step 9, result becomes {code[9:0], 6'b000000}. The high byte therefore holds code[9:2], bits 7:6 hold code[1:0], and bits 5:0 are zero. result changes at no other time.
- R5: irq is high for exactly one cycle: the cycle in which result first shows the new code.
- R6: While enable stays high, the cycle in which irq is high is also the first cycle of the next sampling phase (sample_hold high).
- R7: A chan_wr pulse while enabled, during sampling or any conversion step except the last, restarts sampling at that edge. The count starts over, the partial code is dropped, result keeps its value and no irq is issued.
- R8: A chan_wr pulse in conversion step 9 does not abort the conversion. The transfer and irq happen as usual, and a full sampling phase follows.
- R9: With enable low at an edge, the block is idle from that edge on. sample_hold and trial_code are zero, no irq is issued for the dropped conversion, and result keeps its last value.
- R10: chan_wr has no effect while enable is low. sample_hold stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable level |
| chan_wr | input | 1 | One-cycle strobe: channel select was rewritten |
| cmp_ge | input | 1 | Comparator: held input is at or above trial_code |
| trial_code | output | 10 | Trial code to the DAC during conversion, else zero |
| sample_hold | output | 1 | High during the sampling phase |
| result | output | 16 | Left-justified conversion result, low six bits zero |
| irq | output | 1 | One-cycle completion pulse |

## Verification
Sampling begins at the first edge that sees enable high in idle. Step 0 follows SAMPLE_CLKS cycles later, and result and irq change together at the edge that closes step 9, SAMPLE_CLKS + 10 cycles after sampling starts. A chan_wr or a drop of enable takes effect at the very next edge. The bench steps a behavioural model at each rising edge from the same inputs and compares every output on the falling edge, so each expected value is due exactly one register stage after its cause. The comparator is modelled from a held input level, which makes every finished code equal to that level, and targeted checks strike the restart and abort cases in named steps.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS    = 10,
  parameter int SAMPLE_CLKS = 8,
  localparam int CW = $clog2(SAMPLE_CLKS) + 1,
  localparam int SW = $clog2(RES_BITS) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          chan_wr,
  output logic          sampling,
  output logic          converting,
  output logic          advance,
  output logic          done,
  output logic [SW-1:0] bit_pos
);
  seq_state_t    state;
  logic [CW-1:0] smp_cnt;
  logic [SW-1:0] step;
  logic          last_step;
  logic          abort;

  assign last_step  = (state == ST_CONV) && (step == SW'(RES_BITS - 1));
  assign sampling   = (state == ST_SAMPLE);
  assign converting = (state == ST_CONV);
  assign done       = enable && last_step;
  assign abort      = enable && converting && !last_step && chan_wr;
  assign advance    = enable && converting && !last_step && !chan_wr;
  assign bit_pos    = SW'(RES_BITS - 1) - step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      smp_cnt <= '0;
      step    <= '0;
    end else if (!enable) begin
      state   <= ST_IDLE;
      smp_cnt <= '0;
      step    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          state   <= ST_SAMPLE;
          smp_cnt <= '0;
        end
        ST_SAMPLE: begin
          if (chan_wr) begin
            smp_cnt <= '0;
          end else if (smp_cnt == CW'(SAMPLE_CLKS - 1)) begin
            state   <= ST_CONV;
            step    <= '0;
            smp_cnt <= '0;
          end else begin
            smp_cnt <= smp_cnt + 1'b1;
          end
        end
        ST_CONV: begin
          if (last_step || chan_wr) begin
            state   <= ST_SAMPLE;
            smp_cnt <= '0;
            step    <= '0;
          end else begin
            step <= step + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: a low enable sends the sequencer to idle at the next edge
  a_r9_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (state == ST_IDLE));

  // R7: an abort during conversion restarts the sampling count
  a_r7_abort_restart: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (state == ST_SAMPLE && smp_cnt == '0));

  // R2: the end of sampling leads to conversion step 0
  a_r2_sample_to_conv: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && sampling && !chan_wr && smp_cnt == CW'(SAMPLE_CLKS - 1))
      |=> (converting && step == '0));
endmodule

// File: rtl/sar_seq_approx.sv
module sar_seq_approx #(
  parameter int RES_BITS = 10,
  localparam int SW = $clog2(RES_BITS) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                converting,
  input  logic                advance,
  input  logic [SW-1:0]       bit_pos,
  input  logic                cmp_ge,
  output logic [RES_BITS-1:0] trial_code,
  output logic [RES_BITS-1:0] next_code
);
  logic [RES_BITS-1:0] sar;
  logic [RES_BITS-1:0] mask;

  for (genvar i = 0; i < RES_BITS; i++) begin : g_bit
    assign mask[i]      = converting && (bit_pos == SW'(i));
    assign next_code[i] = mask[i] ? cmp_ge : sar[i];
  end

  assign trial_code = sar | mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sar <= '0;
    else if (advance) sar <= next_code;
    else              sar <= '0;
  end

  // R2: the approximation register is clear outside conversion
  a_r2_sar_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !converting |-> (sar == '0));

  // R3: exactly one trial bit is added on top of the kept bits
  a_r3_one_trial: assert property (@(posedge clk) disable iff (!rst_n)
    converting |-> ($countones(trial_code ^ sar) == 1));

  // R3: kept bits survive a non-aborted step
  a_r3_keep_bits: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> ((sar & $past(sar)) == $past(sar)));
endmodule

// File: rtl/sar_seq_result.sv
module sar_seq_result #(
  parameter int RES_BITS = 10,
  parameter int OUT_BITS = 16,
  localparam int PAD = OUT_BITS - RES_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                done,
  input  logic [RES_BITS-1:0] code,
  output logic [OUT_BITS-1:0] result,
  output logic                irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= done;
      if (done) result <= {code, {PAD{1'b0}}};
    end
  end

  // R5: the interrupt lasts one cycle
  a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R4: result only moves in the cycle flagged by the interrupt
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> $stable(result));
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
  parameter int RES_BITS    = 10,
  parameter int OUT_BITS    = 16,
  parameter int SAMPLE_CLKS = 8,
  localparam int SW = $clog2(RES_BITS) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                chan_wr,
  input  logic                cmp_ge,
  output logic [RES_BITS-1:0] trial_code,
  output logic                sample_hold,
  output logic [OUT_BITS-1:0] result,
  output logic                irq
);
  logic          converting;
  logic          advance;
  logic          done;
  logic [SW-1:0] bit_pos;
  logic [RES_BITS-1:0] next_code;

  sar_seq_ctrl #(.RES_BITS(RES_BITS), .SAMPLE_CLKS(SAMPLE_CLKS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .chan_wr    (chan_wr),
    .sampling   (sample_hold),
    .converting (converting),
    .advance    (advance),
    .done       (done),
    .bit_pos    (bit_pos)
  );

  sar_seq_approx #(.RES_BITS(RES_BITS)) u_approx (
    .clk        (clk),
    .rst_n      (rst_n),
    .converting (converting),
    .advance    (advance),
    .bit_pos    (bit_pos),
    .cmp_ge     (cmp_ge),
    .trial_code (trial_code),
    .next_code  (next_code)
  );

  sar_seq_result #(.RES_BITS(RES_BITS), .OUT_BITS(OUT_BITS)) u_result (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (done),
    .code   (next_code),
    .result (result),
    .irq    (irq)
  );

  // R6: the completion cycle is the first cycle of the next sampling phase
  a_r6_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> sample_hold);

  // R3: the trial code is zero outside conversion
  a_r3_trial_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !converting |-> (trial_code == '0));
endmodule

// File: tb/sar_seq_top_test.sv
module sar_seq_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int SMP = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       chan_wr = 1'b0;
  logic       cmp_ge;
  logic [9:0] trial_code;
  logic       sample_hold;
  logic [15:0] result;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int ain = 0;

  // behavioural reference state
  int m_ph = 0;      // 0 idle, 1 sampling, 2 converting
  int m_cnt = 0;
  int m_k = 0;
  int m_acc = 0;
  int m_res = 0;
  int m_irq = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // comparator: held input level against the driven trial code
  assign cmp_ge = (ain >= int'(trial_code));

  sar_seq_top #(.SAMPLE_CLKS(SMP)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .chan_wr(chan_wr),
    .cmp_ge(cmp_ge), .trial_code(trial_code), .sample_hold(sample_hold),
    .result(result), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_trial();
    if (m_ph == 2) return m_acc | (1 << (9 - m_k));
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_k = 0; m_acc = 0; m_res = 0; m_irq = 0;
    end else begin
      m_irq = 0;
      if (!enable) begin
        m_ph = 0; m_cnt = 0; m_k = 0; m_acc = 0;
      end else if (m_ph == 0) begin
        m_ph = 1; m_cnt = 0;
      end else if (m_ph == 1) begin
        if (chan_wr) m_cnt = 0;
        else if (m_cnt == SMP - 1) begin m_ph = 2; m_k = 0; m_acc = 0; end
        else m_cnt++;
      end else begin
        int t;
        int nacc;
        t = m_acc | (1 << (9 - m_k));
        nacc = (ain >= t) ? t : m_acc;
        if (m_k == 9) begin
          m_res = nacc << 6; m_irq = 1; m_ph = 1; m_cnt = 0; m_acc = 0; m_k = 0;
        end else if (chan_wr) begin
          m_ph = 1; m_cnt = 0; m_acc = 0; m_k = 0;
        end else begin
          m_acc = nacc; m_k++;
        end
      end
    end
  end

  // every-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 sample_hold", int'(sample_hold), (m_ph == 1) ? 1 : 0);
      check("R3 trial_code", int'(trial_code), exp_trial());
      check("R5 irq", int'(irq), m_irq);
      check("R4 result", int'(result), m_res);
    end
  end

  task automatic wait_step(input int ph, input int k);
    while (!(m_ph == ph && (ph != 2 || m_k == k))) @(negedge clk);
  endtask

  task automatic wait_irq();
    @(negedge clk);
    while (irq !== 1'b1) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 result", int'(result), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 sample_hold", int'(sample_hold), 0);
    check("R1 trial_code", int'(trial_code), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 result after release", int'(result), 0);

    // R2/R3/R4: first conversion from idle
    ain = 10'h2A5;
    enable = 1'b1;
    @(negedge clk);
    check("R2 sampling begins", int'(sample_hold), 1);
    wait_irq();
    check("R4 code 2A5", int'(result), 16'hA940);
    check("R4 high byte", int'(result[15:8]), 8'hA9);
    check("R4 low byte bits 7:6", int'(result[7:6]), 1);
    check("R4 low six zero", int'(result[5:0]), 0);
    check("R6 sampling with irq", int'(sample_hold), 1);

    // R6: back-to-back conversions with other levels
    ain = 1023;
    wait_irq();
    check("R4 full scale", int'(result), 16'hFFC0);
    ain = 0;
    wait_irq();
    check("R4 zero", int'(result), 0);
    ain = 10'h155;
    wait_irq();
    check("R4 alternating", int'(result), 16'h5540);

    // R7: rewrite during sampling and mid-conversion
    ain = 10'h0F0;
    @(negedge clk);
    wait_step(1, 0);
    repeat (3) @(negedge clk);
    chan_wr = 1'b1;
    @(negedge clk);
    chan_wr = 1'b0;
    check("R7 restart in sampling", int'(sample_hold), 1);
    wait_step(2, 4);
    held = result;
    chan_wr = 1'b1;
    @(negedge clk);
    chan_wr = 1'b0;
    check("R7 sampling after abort", int'(sample_hold), 1);
    check("R7 trial cleared", int'(trial_code), 0);
    check("R7 result kept", int'(result), int'(held));
    check("R7 no irq", int'(irq), 0);

    // R8: rewrite in the last step still delivers
    wait_step(2, 9);
    chan_wr = 1'b1;
    @(negedge clk);
    chan_wr = 1'b0;
    check("R8 irq on last-step rewrite", int'(irq), 1);
    check("R8 result delivered", int'(result), 16'h3C00);
    check("R8 sampling follows", int'(sample_hold), 1);

    // R9: disable mid-conversion
    ain = 10'h3FF;
    wait_step(2, 5);
    held = result;
    enable = 1'b0;
    @(negedge clk);
    check("R9 idle sample_hold", int'(sample_hold), 0);
    check("R9 idle trial", int'(trial_code), 0);
    check("R9 result kept", int'(result), int'(held));
    repeat (SMP + 12) begin
      @(negedge clk);
      check("R9 no irq", int'(irq), 0);
    end

    // R10: rewrite while disabled is ignored
    chan_wr = 1'b1;
    repeat (3) @(negedge clk);
    chan_wr = 1'b0;
    @(negedge clk);
    check("R10 still idle", int'(sample_hold), 0);
    check("R10 result kept", int'(result), int'(held));

    // re-enable after idle: conversion runs again
    ain = 10'h001;
    enable = 1'b1;
    wait_irq();
    check("R2 restart after idle", int'(result), 16'h0040);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule